// File: doc/BRIEF.md
# Direct-Mapped Window Address Translator

This block is the first stage of virtual-to-physical address translation. For every access it decides which of four paths applies. Direct addressing passes the address straight through. A hit in one of four direct-mapped windows gives a fixed translation. A non-canonical address is rejected as bad. Anything else is handed on to the TLB and page-walk path, which sits outside this block. The inputs are the virtual address, the access privilege, a 32/64-bit mode flag, the direct-address and paging-enable bits of the mode register, and four window configuration words.

Each window word carries two privilege enables, a virtual segment to compare against the top bits of the address and, for 32-bit mode, a physical segment that replaces the top address bits. Windows are searched from index 0 upward, and the lowest matching enabled window wins. Any match, direct or windowed, grants read, write and execute permission.

The translation is combinational. The parameter `OUT_REG` selects an optional register stage on the outputs. The outputs are a 64-bit physical address, a 3-bit permission vector and a 2-bit result code.

Top module: `dmw_xlate_top`

## Requirements
- R1: With `direct_en`=1 and `paging_en`=0, `pa` equals `va` with all bits at and above `PHYS_W` cleared, `perm` is 3'b111 and `result` is 2'b01 (match). Window contents play no part.
- R2: A window can hit only if its enable bit for the current privilege is set. For kernel access (`priv_user`=0) that is bit 0 of the window word; for user access (`priv_user`=1) it is bit 3. A window whose enable bit is clear never hits.
- R3: When several enabled windows match, the one with the lowest index supplies the translation.
- R4: In 64-bit mode (`mode64`=1) a window matches when `va[63:60]` equals bits [63:60] of the window word. The result `pa` is `va[VIRT_W-1:0]` zero-extended to 64 bits.
- R5: In 32-bit mode (`mode64`=0) a window matches when `va[31:29]` equals bits [31:29] of the window word. The result `pa` is {window bits [27:25], `va[28:0]`} zero-extended to 64 bits.
- R6: A window hit gives `result` 2'b01 and `perm` 3'b111. In `perm`, bit 0 is read, bit 1 is write and bit 2 is execute.
- R7: With no direct match and no window hit, if `va[VIRT_W+15:VIRT_W]` is neither all zeros nor all ones, `result` is 2'b10 (bad address), and `pa` and `perm` are zero.
- R8: A canonical address that hits no window gives `result` 2'b00 (forward to TLB), with `pa` and `perm` zero.
- R9: Every `direct_en`/`paging_en` combination other than 1/0 (that is 0/0, 0/1 and 1/1) takes the window path.
- R10: With `OUT_REG`=1 the outputs show the translation of the inputs present at the previous rising clock edge, and reset clears them to zero (`result` 2'b00). With `OUT_REG`=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| va | input | 64 | Virtual address |
| priv_user | input | 1 | 1 = user access, 0 = kernel access |
| mode64 | input | 1 | 1 = 64-bit segment format, 0 = 32-bit format |
| direct_en | input | 1 | Direct-address bit of the mode register |
| paging_en | input | 1 | Paging-enable bit of the mode register |
| win_cfg | input | NUM_WIN*64 | Window words, window i in bits [64*i+63:64*i] |
| pa | output | 64 | Physical address |
| perm | output | 3 | Permissions {exec, write, read} |
| result | output | 2 | 00 forward, 01 match, 10 bad address |

## Verification
The bench builds two copies side by side. Both use `PHYS_W`=44 and `VIRT_W`=48; one has `OUT_REG`=1 and the other `OUT_REG`=0, so the same stimulus checks the same-cycle path and the one-cycle registered path, including reset clearing the register. Because the physical width differs from the virtual width, a mix-up between the direct mask (R1) and the 64-bit window mask (R4) shows up at the outputs. Window segments and address top bits are drawn from a small pool, so overlapping windows, privilege-gated misses and near-canonical addresses all occur often.

// File: rtl/dmw_pkg.sv
`timescale 1ns/1ps
package dmw_pkg;

  localparam int unsigned ADDR_W      = 64;
  localparam int unsigned CFG_W       = 64;
  localparam int unsigned KEN_BIT     = 0;   // kernel enable in window word
  localparam int unsigned UEN_BIT     = 3;   // user enable in window word
  localparam int unsigned SEG64_LSB   = 60;
  localparam int unsigned SEG32_LSB   = 29;
  localparam int unsigned PSEG32_LSB  = 25;
  localparam int unsigned SEG64_W     = 4;
  localparam int unsigned SEG32_W     = 3;
  localparam int unsigned CANON_W     = 16;

  typedef enum logic [1:0] {
    XL_FWD = 2'b00,
    XL_HIT = 2'b01,
    XL_BAD = 2'b10
  } xl_res_e;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CFG_W-1:0]  wcfg_t;
  typedef logic [2:0]        perm_t;

  localparam perm_t PERM_RWX  = 3'b111;
  localparam perm_t PERM_NONE = 3'b000;

  // Low-bit mask of the given width.
  function automatic addr_t low_mask(input int unsigned w);
    addr_t m;
    m = '0;
    for (int unsigned b = 0; b < ADDR_W; b++) begin
      if (b < w) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Segment of an address, in the format the mode selects.
  function automatic logic [SEG64_W-1:0] va_segment(input addr_t v, input logic m64);
    logic [SEG64_W-1:0] s;
    if (m64) s = v[SEG64_LSB +: SEG64_W];
    else     s = {1'b0, v[SEG32_LSB +: SEG32_W]};
    return s;
  endfunction

  // Virtual segment held in a window word.
  function automatic logic [SEG64_W-1:0] cfg_segment(input wcfg_t c, input logic m64);
    logic [SEG64_W-1:0] s;
    if (m64) s = c[SEG64_LSB +: SEG64_W];
    else     s = {1'b0, c[SEG32_LSB +: SEG32_W]};
    return s;
  endfunction

  // Privilege enable of a window word.
  function automatic logic cfg_allows(input wcfg_t c, input logic user);
    return user ? c[UEN_BIT] : c[KEN_BIT];
  endfunction

  // Physical address produced by a window hit.
  function automatic addr_t window_pa(input addr_t v, input wcfg_t c,
                                      input logic m64, input addr_t vmask);
    addr_t p;
    if (m64) begin
      p = v & vmask;
    end else begin
      p = '0;
      p[SEG32_LSB-1:0] = v[SEG32_LSB-1:0];
      p[SEG32_LSB +: SEG32_W] = c[PSEG32_LSB +: SEG32_W];
    end
    return p;
  endfunction

  // Sign-extension test of the bits above the virtual space.
  function automatic logic upper_canonical(input addr_t v, input int unsigned vw);
    logic [CANON_W-1:0] hi;
    hi = CANON_W'(v >> vw);
    return (hi == '0) || (hi == '1);
  endfunction

endpackage

// File: rtl/dmw_window_match.sv
`timescale 1ns/1ps
module dmw_window_match
  import dmw_pkg::*;
#(
  parameter int unsigned VIRT_W = 48
) (
  input  addr_t va,
  input  wcfg_t cfg,
  input  logic  mode64,
  input  logic  priv_user,
  output logic  hit,
  output addr_t hit_pa
);
  localparam addr_t VMASK = low_mask(VIRT_W);

  logic seg_eq;
  logic priv_ok;

  always_comb begin
    seg_eq  = (va_segment(va, mode64) == cfg_segment(cfg, mode64));
    priv_ok = cfg_allows(cfg, priv_user);
    hit     = seg_eq & priv_ok;
    hit_pa  = window_pa(va, cfg, mode64, VMASK);
  end
endmodule

// File: rtl/dmw_prio_select.sv
`timescale 1ns/1ps
module dmw_prio_select
  import dmw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic [NUM_WIN-1:0]        hit_vec,
  input  logic [NUM_WIN-1:0][63:0]  pa_vec,
  output logic                      any_hit,
  output logic [NUM_WIN-1:0]        sel_onehot,
  output addr_t                     sel_pa
);
  always_comb begin
    logic taken;
    taken      = 1'b0;
    sel_onehot = '0;
    sel_pa     = '0;
    for (int i = 0; i < int'(NUM_WIN); i++) begin
      if (hit_vec[i] && !taken) begin
        taken         = 1'b1;
        sel_onehot[i] = 1'b1;
        sel_pa        = pa_vec[i];
      end
    end
    any_hit = taken;
  end
endmodule

// File: rtl/dmw_canon_check.sv
`timescale 1ns/1ps
module dmw_canon_check
  import dmw_pkg::*;
#(
  parameter int unsigned VIRT_W = 48
) (
  input  addr_t va,
  output logic  canon_ok
);
  always_comb canon_ok = upper_canonical(va, VIRT_W);
endmodule

// File: rtl/dmw_xlate_top.sv
`timescale 1ns/1ps
module dmw_xlate_top
  import dmw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned VIRT_W  = 48,
  parameter int unsigned PHYS_W  = 48,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [63:0]          va,
  input  logic                 priv_user,
  input  logic                 mode64,
  input  logic                 direct_en,
  input  logic                 paging_en,
  input  logic [NUM_WIN*64-1:0] win_cfg,
  output logic [63:0]          pa,
  output logic [2:0]           perm,
  output logic [1:0]           result
);
  localparam addr_t PMASK = low_mask(PHYS_W);

  // Named internal events, observed by the bound checker.
  logic                      direct_take;
  logic [NUM_WIN-1:0]        hit_vec;
  logic [NUM_WIN-1:0][63:0]  pa_vec;
  logic                      any_hit;
  logic [NUM_WIN-1:0]        sel_onehot;
  addr_t                     sel_pa;
  logic                      canon_ok;
  addr_t                     nxt_pa;
  perm_t                     nxt_perm;
  xl_res_e                   nxt_result;

  assign direct_take = direct_en & ~paging_en;

  for (genvar g = 0; g < int'(NUM_WIN); g++) begin : g_win
    dmw_window_match #(.VIRT_W(VIRT_W)) u_match (
      .va        (va),
      .cfg       (win_cfg[g*64 +: 64]),
      .mode64    (mode64),
      .priv_user (priv_user),
      .hit       (hit_vec[g]),
      .hit_pa    (pa_vec[g])
    );
  end

  dmw_prio_select #(.NUM_WIN(NUM_WIN)) u_prio (
    .hit_vec    (hit_vec),
    .pa_vec     (pa_vec),
    .any_hit    (any_hit),
    .sel_onehot (sel_onehot),
    .sel_pa     (sel_pa)
  );

  dmw_canon_check #(.VIRT_W(VIRT_W)) u_canon (
    .va       (va),
    .canon_ok (canon_ok)
  );

  always_comb begin
    nxt_pa     = '0;
    nxt_perm   = PERM_NONE;
    nxt_result = XL_FWD;
    if (direct_take) begin
      nxt_pa     = va & PMASK;
      nxt_perm   = PERM_RWX;
      nxt_result = XL_HIT;
    end else if (any_hit) begin
      nxt_pa     = sel_pa;
      nxt_perm   = PERM_RWX;
      nxt_result = XL_HIT;
    end else if (!canon_ok) begin
      nxt_result = XL_BAD;
    end
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pa     <= '0;
        perm   <= '0;
        result <= '0;
      end else begin
        pa     <= nxt_pa;
        perm   <= nxt_perm;
        result <= nxt_result;
      end
    end
  end else begin : g_comb
    always_comb begin
      pa     = nxt_pa;
      perm   = nxt_perm;
      result = nxt_result;
    end
  end
endmodule

// File: rtl/dmw_xlate_chk.sv
`timescale 1ns/1ps
module dmw_xlate_chk #(
  parameter int unsigned NUM_WIN = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               direct_take,
  input logic [NUM_WIN-1:0] hit_vec,
  input logic [NUM_WIN-1:0] sel_onehot,
  input logic               any_hit,
  input logic               canon_ok,
  input logic [63:0]        nxt_pa,
  input logic [2:0]         nxt_perm,
  input logic [1:0]         nxt_result,
  input logic [63:0]        pa,
  input logic [2:0]         perm,
  input logic [1:0]         result
);
  AST_DIRECT_RWX: assert property (@(posedge clk) disable iff (!rst_n)
    direct_take |-> (nxt_result == 2'b01 && nxt_perm == 3'b111)); // R1

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot)); // R3

  AST_SEL_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_onehot & ~hit_vec) == '0); // R3

  AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec[0] |-> sel_onehot[0])); // R3

  AST_HIT_RWX: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_take && any_hit) |-> (nxt_result == 2'b01 && nxt_perm == 3'b111)); // R6

  AST_BAD_NONCANON: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_result == 2'b10) |-> (!canon_ok && !any_hit && nxt_perm == 3'b000 && nxt_pa == '0)); // R7

  AST_FWD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_result == 2'b00) |-> (nxt_perm == 3'b000 && nxt_pa == '0 && canon_ok)); // R8

  if (OUT_REG) begin : g_reg_chk
    AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (result == $past(nxt_result) && perm == $past(nxt_perm)
                && pa == $past(nxt_pa))); // R10
  end
endmodule

bind dmw_xlate_top dmw_xlate_chk #(.NUM_WIN(NUM_WIN), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .direct_take (direct_take),
  .hit_vec     (hit_vec),
  .sel_onehot  (sel_onehot),
  .any_hit     (any_hit),
  .canon_ok    (canon_ok),
  .nxt_pa      (nxt_pa),
  .nxt_perm    (nxt_perm),
  .nxt_result  (nxt_result),
  .pa          (pa),
  .perm        (perm),
  .result      (result)
);

// File: tb/test_dmw_xlate_top.sv
`timescale 1ns/1ps
module test_dmw_xlate_top;
  localparam int PW = 44;
  localparam int VW = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] t_va = '0;
  logic        t_user = 1'b0;
  logic        t_m64 = 1'b1;
  logic        t_da = 1'b0;
  logic        t_pg = 1'b1;
  logic [63:0] t_cfg [4];
  logic [255:0] cfg_flat;

  logic [63:0] r_pa, c_pa;
  logic [2:0]  r_perm, c_perm;
  logic [1:0]  r_res, c_res;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  always_comb cfg_flat = {t_cfg[3], t_cfg[2], t_cfg[1], t_cfg[0]};

  dmw_xlate_top #(.NUM_WIN(4), .VIRT_W(VW), .PHYS_W(PW), .OUT_REG(1'b1)) i_dmw_xlate_top (
    .clk(clk), .rst_n(rst_n), .va(t_va), .priv_user(t_user), .mode64(t_m64),
    .direct_en(t_da), .paging_en(t_pg), .win_cfg(cfg_flat),
    .pa(r_pa), .perm(r_perm), .result(r_res));

  dmw_xlate_top #(.NUM_WIN(4), .VIRT_W(VW), .PHYS_W(PW), .OUT_REG(1'b0)) i_comb (
    .clk(clk), .rst_n(rst_n), .va(t_va), .priv_user(t_user), .mode64(t_m64),
    .direct_en(t_da), .paging_en(t_pg), .win_cfg(cfg_flat),
    .pa(c_pa), .perm(c_perm), .result(c_res));

  // Behavioural reference built from the requirement text.
  task automatic model(output logic [63:0] e_pa, output logic [2:0] e_perm,
                       output logic [1:0] e_res, output string tag);
    int pbit;
    longint unsigned hi;
    longint unsigned vseg, cseg;
    e_pa = 0; e_perm = 0; e_res = 2'b00; tag = "R8";
    if (t_da && !t_pg) begin
      e_pa = t_va % (64'd1 << PW); e_perm = 3'b111; e_res = 2'b01; tag = "R1";
      return;
    end
    pbit = t_user ? 3 : 0;
    for (int i = 0; i < 4; i++) begin
      if (t_m64) begin vseg = t_va >> 60; cseg = t_cfg[i] >> 60; end
      else begin vseg = (t_va >> 29) & 7; cseg = (t_cfg[i] >> 29) & 7; end
      if (t_cfg[i][pbit] && vseg == cseg) begin
        e_perm = 3'b111; e_res = 2'b01;
        if (t_m64) begin e_pa = t_va % (64'd1 << VW); tag = "R4"; end
        else begin
          e_pa = (t_va % (64'd1 << 29)) + (((t_cfg[i] >> 25) & 7) << 29);
          tag = "R5";
        end
        return;
      end
    end
    hi = t_va >> VW;
    if (hi != 0 && hi != 64'hFFFF) begin e_res = 2'b10; tag = "R7"; end
  endtask

  task automatic compare(input string who, input string tag,
                         input logic [63:0] a_pa, input logic [2:0] a_perm, input logic [1:0] a_res,
                         input logic [63:0] e_pa, input logic [2:0] e_perm, input logic [1:0] e_res);
    checks++;
    if (a_pa !== e_pa || a_perm !== e_perm || a_res !== e_res) begin
      fails++;
      $display("FAIL %s %s: actual pa=%h perm=%b res=%b expected pa=%h perm=%b res=%b",
               tag, who, a_pa, a_perm, a_res, e_pa, e_perm, e_res);
    end
  endtask

  // Drive at negedge, check comb copy, then registered copy one edge later (R10).
  task automatic step(input string force_tag);
    logic [63:0] e_pa; logic [2:0] e_perm; logic [1:0] e_res; string tag;
    #1;
    model(e_pa, e_perm, e_res, tag);
    if (force_tag != "") tag = force_tag;
    compare("comb", tag, c_pa, c_perm, c_res, e_pa, e_perm, e_res);
    @(posedge clk); #1;
    compare("reg R10", tag, r_pa, r_perm, r_res, e_pa, e_perm, e_res);
    @(negedge clk);
  endtask

  function automatic logic [63:0] wcfg64(input logic [3:0] seg, input bit ken, input bit uen);
    logic [63:0] c;
    c = '0; c[63:60] = seg; c[0] = ken; c[3] = uen;
    return c;
  endfunction

  function automatic logic [63:0] wcfg32(input logic [2:0] vseg, input logic [2:0] pseg,
                                         input bit ken, input bit uen);
    logic [63:0] c;
    c = '0; c[31:29] = vseg; c[27:25] = pseg; c[0] = ken; c[3] = uen;
    return c;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) t_cfg[i] = '0;
    // Reset: direct mode on inputs, registered copy must stay cleared (R10).
    t_da = 1'b1; t_pg = 1'b0; t_va = 64'hFFFF_ABCD_1234_5678;
    repeat (3) @(posedge clk);
    #1;
    compare("reg reset R10", "R10", r_pa, r_perm, r_res, 64'd0, 3'b000, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: direct addressing masks to PHYS_W, windows ignored.
    t_cfg[0] = wcfg64(4'hF, 1, 1);
    step("R1");
    // R9: other mode-bit combinations use windows.
    t_da = 1'b1; t_pg = 1'b1; step("R9");
    t_da = 1'b0; t_pg = 1'b0; step("R9");
    t_da = 1'b0; t_pg = 1'b1; step("R9");

    // R4: 64-bit hit in window 2 only.
    for (int i = 0; i < 4; i++) t_cfg[i] = '0;
    t_cfg[2] = wcfg64(4'h9, 1, 0);
    t_va = 64'h9000_7FFF_DEAD_BEEF; t_user = 0; step("R4");
    // R2: user access blocked by missing user enable; non-canonical -> bad.
    t_user = 1; step("R2");
    // R2: user enable alone admits user access, blocks kernel.
    t_cfg[2] = wcfg64(4'h9, 0, 1); step("R2");
    t_user = 0; step("R2");

    // R3: windows 1 and 3 both match, 1 wins; then 0 takes over.
    t_cfg[1] = wcfg64(4'h8, 1, 1); t_cfg[3] = wcfg64(4'h8, 1, 1);
    t_cfg[1][27:25] = 3'b101; t_cfg[3][27:25] = 3'b010;
    t_va = 64'h8000_1234_5678_9ABC; step("R3");
    t_cfg[0] = wcfg64(4'h8, 1, 0); step("R3");

    // R5: 32-bit physical segment substitution, priority among 32-bit windows.
    t_m64 = 0;
    for (int i = 0; i < 4; i++) t_cfg[i] = '0;
    t_cfg[1] = wcfg32(3'b101, 3'b011, 1, 0);
    t_cfg[2] = wcfg32(3'b101, 3'b110, 1, 0);
    t_va = 64'h0000_0000_B234_5678; step("R5");
    t_va = 64'h0000_0000_5234_5678; step("R8");

    // R7/R8: canonical edge cases with no hit.
    t_m64 = 1;
    for (int i = 0; i < 4; i++) t_cfg[i] = '0;
    t_va = 64'h0000_FFFF_FFFF_FFFF; step("R8");
    t_va = 64'hFFFF_0000_0000_0000; step("R8");
    t_va = 64'h0001_0000_0000_0000; step("R7");
    t_va = 64'h7FFF_0000_0000_0000; step("R7");

    // Mixed stimulus from a small segment pool.
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 4; i++) begin
        t_cfg[i] = {$urandom, $urandom};
        t_cfg[i][63:60] = 4'($urandom_range(0, 2) == 0 ? 4'h0 : ($urandom_range(0, 1) ? 4'hF : 4'h9));
        t_cfg[i][31:29] = 3'($urandom_range(0, 2));
      end
      case ($urandom_range(0, 3))
        0: t_va = {16'h0000, 16'($urandom), $urandom};
        1: t_va = {16'hFFFF, 16'($urandom), $urandom};
        2: t_va = {4'h9, 12'($urandom_range(0, 1) ? 0 : $urandom), 16'($urandom), $urandom};
        default: t_va = {$urandom, $urandom};
      endcase
      t_va[31:29] = 3'($urandom_range(0, 3));
      t_user = 1'($urandom);
      t_m64  = 1'($urandom);
      t_da   = ($urandom_range(0, 7) == 0);
      t_pg   = 1'($urandom);
      step("");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule